// File: doc/BRIEF.md
# Shared-Buffer Multichannel Stream FIFO Interface

This block sits between a DMA engine and an audio streaming fabric. It carries a set of transmit (memory-to-stream) channels and a set of receive (stream-to-memory) channels. All of them keep their words in one shared storage array. Configuration gives each channel its own slice of that array as a base offset and a depth, plus a start level for the transmit channels. The DMA writes words into transmit FIFOs and reads words back from receive FIFOs. The streaming side pops transmit words and pushes captured receive words.

Flow control toward the DMA uses only per-word events. Every word popped downstream on a transmit channel, and every word pushed into a receive channel, produces a one-cycle pulse on that channel's event bit. The DMA keeps its own occupancy count from these pulses. The block raises no level or watermark request.

A transmit channel offers nothing downstream until its fill level has reached the programmed start level. After that it drains while it holds data, and it arms again when it runs empty or is reconfigured. Receive channels have no start level. A producer that writes into a full FIFO sets a sticky error bit for that channel.

Top module: `sbf_stream_if`

## Requirements
- R1: After reset, every transmit availability bit, event bit, error bit and data-valid output is 0, and each channel has depth 0.
- R2: Channel index selection: transmit channels are numbered 0..N_TX-1 on the DMA write and stream pop ports. Receive channels are numbered 0..N_RX-1 on the stream push and DMA read ports. On the configuration port, index k below N_TX selects transmit channel k, and index N_TX+j selects receive channel j.
- R3: A transmit channel's availability bit stays 0 while its fill level is below its start level. It goes to 1 after the clock edge that brings the level to the start level. With a start level of 16, two bursts of 8 writes are needed.
- R4: Once available, a transmit channel stays available while its fill level is non-zero, even below the start level. It drops to 0 when it empties, and the start level must be reached again before it returns.
- R5: A stream pop on an available transmit channel returns the oldest word on the stream data output, with the stream data-valid output at 1, in the cycle after the pop edge. The same cycle carries a one-cycle pulse on that channel's transmit event bit. A pop on an unavailable channel is ignored: no valid data and no event.
- R6: Each stream push into a non-full receive channel produces a one-cycle pulse on that channel's receive event bit in the next cycle, with no start level.
- R7: A DMA read of a non-empty receive channel returns its oldest word, with the DMA data-valid output at 1, one cycle later. A read of an empty receive channel gives data-valid 0.
- R8: Each channel's pointers wrap inside its own region, from base to base+depth-1. Traffic on one channel does not alter the words held by another.
- R9: A write into a full transmit FIFO, or a push into a full receive FIFO, drops the word and sets that channel's error bit. The bit stays set.
- R10: A configuration write to a channel empties it, closes its start gate and clears its error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CW | Channel selected for configuration (tx first, then rx) |
| cfg_base | input | AW | Region base offset in the shared array |
| cfg_depth | input | AW+1 | Region depth in words |
| cfg_thresh | input | AW+1 | Transmit start level (ignored for rx) |
| dma_tx_we | input | 1 | DMA write into a transmit FIFO |
| dma_tx_ch | input | TW | Transmit channel for the DMA write |
| dma_tx_data | input | DATA_W | DMA write word |
| dma_rx_re | input | 1 | DMA read from a receive FIFO |
| dma_rx_ch | input | RW | Receive channel for the DMA read |
| dma_rx_data | output | DATA_W | DMA read word |
| dma_rx_dval | output | 1 | DMA read word valid |
| strm_tx_pop | input | 1 | Stream pop from a transmit FIFO |
| strm_tx_ch | input | TW | Transmit channel for the pop |
| strm_tx_avail | output | N_TX | Per-channel transmit availability |
| strm_tx_data | output | DATA_W | Popped word |
| strm_tx_dval | output | 1 | Popped word valid |
| strm_rx_push | input | 1 | Stream push into a receive FIFO |
| strm_rx_ch | input | RW | Receive channel for the push |
| strm_rx_data | input | DATA_W | Pushed word |
| evt_tx | output | N_TX | Per-word transmit event pulses |
| evt_rx | output | N_RX | Per-word receive event pulses |
| err_tx | output | N_TX | Sticky transmit overflow flags |
| err_rx | output | N_RX | Sticky receive overflow flags |

## Verification
Every result is registered once. Popped data, DMA read data, both valids and both event vectors appear in the cycle after the accepting edge. Availability and error bits change at the edge that moves the fill level. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It then samples 1 ns after that edge, before the next falling edge, so each check sees the result of that single edge and nothing later. Boundary checks are placed on the edge just before and the edge just at a level change: the fifteenth and sixteenth write of the start level, the last pop to empty, and the depth-th and depth-plus-one-th write.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } chan_dir_e;

  // width of an index field able to name n items (at least one bit)
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sbf_store.sv
module sbf_store #(
  parameter int AW     = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_a,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] da,
  input  logic              we_b,
  input  logic [AW-1:0]     wb,
  input  logic [DATA_W-1:0] db,
  input  logic              re_t,
  input  logic [AW-1:0]     rt,
  input  logic              re_r,
  input  logic [AW-1:0]     rr,
  output logic [DATA_W-1:0] q_t,
  output logic              v_t,
  output logic [DATA_W-1:0] q_r,
  output logic              v_r
);
  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we_a) mem[wa] <= da;
    if (we_b) mem[wb] <= db;
    if (re_t) q_t <= mem[rt];
    if (re_r) q_r <= mem[rr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_t <= 1'b0;
      v_r <= 1'b0;
    end else begin
      v_t <= re_t;
      v_r <= re_r;
    end
  end
endmodule

// File: rtl/sbf_chan.sv
module sbf_chan
  import sbf_pkg::*;
#(
  parameter int        AW  = 6,
  parameter chan_dir_e DIR = DIR_TX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW:0]   cfg_depth,
  input  logic [AW:0]   cfg_thr,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          avail,
  output logic          err
);
  logic [AW-1:0] base_q;
  logic [AW:0]   depth_q, thr_q, wr_off_q, rd_off_q, cnt_q, cnt_nx;
  logic          open_q, full, empty;

  // next offset inside the region, wrapping at depth
  function automatic logic [AW:0] off_step(logic [AW:0] off, logic [AW:0] dep);
    logic [AW:0] inc;
    inc = off + 1'b1;
    return (inc >= dep) ? '0 : inc;
  endfunction

  // absolute array address of a region offset
  function automatic logic [AW-1:0] phys_of(logic [AW-1:0] base, logic [AW:0] off);
    return base + off[AW-1:0];
  endfunction

  // start gate: opens at the start level, holds while data remains
  function automatic logic gate_next(logic open, logic [AW:0] cnt, logic [AW:0] thr);
    return (cnt != '0) && (open || (cnt >= thr));
  endfunction

  assign full    = (cnt_q == depth_q);
  assign empty   = (cnt_q == '0);
  assign wr_ok   = wr_req && !full;
  assign rd_ok   = rd_req && ((DIR == DIR_TX) ? open_q : !empty);
  assign cnt_nx  = cnt_q + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
  assign wr_addr = phys_of(base_q, wr_off_q);
  assign rd_addr = phys_of(base_q, rd_off_q);
  assign avail   = (DIR == DIR_TX) ? open_q : !empty;
  assign err     = err_q;

  logic err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      depth_q  <= '0;
      thr_q    <= '0;
      wr_off_q <= '0;
      rd_off_q <= '0;
      cnt_q    <= '0;
      open_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (cfg_wr) begin
      base_q   <= cfg_base;
      depth_q  <= cfg_depth;
      thr_q    <= cfg_thr;
      wr_off_q <= '0;
      rd_off_q <= '0;
      cnt_q    <= '0;
      open_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (wr_ok) wr_off_q <= off_step(wr_off_q, depth_q);
      if (rd_ok) rd_off_q <= off_step(rd_off_q, depth_q);
      cnt_q  <= cnt_nx;
      open_q <= (DIR == DIR_TX) ? gate_next(open_q, cnt_nx, thr_q) : 1'b0;
      err_q  <= err_q || (wr_req && full);
    end
  end

  // R9
  cnt_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= depth_q);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !cfg_wr) |=> err_q);

  // R4
  open_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (cnt_q != '0));

  // R10
  cfg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cnt_q == '0) && !open_q && !err_q);

  if (DIR == DIR_TX) begin : g_tx_chk
    // R3
    gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> (cnt_q >= thr_q));
  end
endmodule

// File: rtl/sbf_stream_if.sv
module sbf_stream_if
  import sbf_pkg::*;
#(
  parameter int N_TX   = 2,
  parameter int N_RX   = 2,
  parameter int AW     = 6,
  parameter int DATA_W = 16,
  localparam int NCH   = N_TX + N_RX,
  localparam int CW    = idx_w(NCH),
  localparam int TW    = idx_w(N_TX),
  localparam int RW    = idx_w(N_RX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_ch,
  input  logic [AW-1:0]     cfg_base,
  input  logic [AW:0]       cfg_depth,
  input  logic [AW:0]       cfg_thresh,
  input  logic              dma_tx_we,
  input  logic [TW-1:0]     dma_tx_ch,
  input  logic [DATA_W-1:0] dma_tx_data,
  input  logic              dma_rx_re,
  input  logic [RW-1:0]     dma_rx_ch,
  output logic [DATA_W-1:0] dma_rx_data,
  output logic              dma_rx_dval,
  input  logic              strm_tx_pop,
  input  logic [TW-1:0]     strm_tx_ch,
  output logic [N_TX-1:0]   strm_tx_avail,
  output logic [DATA_W-1:0] strm_tx_data,
  output logic              strm_tx_dval,
  input  logic              strm_rx_push,
  input  logic [RW-1:0]     strm_rx_ch,
  input  logic [DATA_W-1:0] strm_rx_data,
  output logic [N_TX-1:0]   evt_tx,
  output logic [N_RX-1:0]   evt_rx,
  output logic [N_TX-1:0]   err_tx,
  output logic [N_RX-1:0]   err_rx
);
  logic [NCH-1:0] wr_ok, rd_ok;
  logic [AW-1:0]  waddr [NCH];
  logic [AW-1:0]  raddr [NCH];
  logic [N_RX-1:0] rx_avail;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_req, rd_req, av, er;
    if (g < N_TX) begin : g_tx
      assign wr_req = dma_tx_we && (dma_tx_ch == TW'(g));
      assign rd_req = strm_tx_pop && (strm_tx_ch == TW'(g));
      assign strm_tx_avail[g] = av;
      assign err_tx[g] = er;
    end else begin : g_rx
      assign wr_req = strm_rx_push && (strm_rx_ch == RW'(g - N_TX));
      assign rd_req = dma_rx_re && (dma_rx_ch == RW'(g - N_TX));
      assign rx_avail[g-N_TX] = av;
      assign err_rx[g-N_TX] = er;
    end

    sbf_chan #(
      .AW (AW),
      .DIR((g < N_TX) ? DIR_TX : DIR_RX)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_we && (cfg_ch == CW'(g))),
      .cfg_base (cfg_base),
      .cfg_depth(cfg_depth),
      .cfg_thr  (cfg_thresh),
      .wr_req   (wr_req),
      .rd_req   (rd_req),
      .wr_ok    (wr_ok[g]),
      .rd_ok    (rd_ok[g]),
      .wr_addr  (waddr[g]),
      .rd_addr  (raddr[g]),
      .avail    (av),
      .err      (er)
    );
  end

  // port address selection by channel index
  logic [AW-1:0] a_wa, b_wa, t_ra, r_ra;
  always_comb begin
    a_wa = '0;
    t_ra = '0;
    for (int i = 0; i < N_TX; i++) begin
      if (dma_tx_ch == TW'(i))  a_wa = waddr[i];
      if (strm_tx_ch == TW'(i)) t_ra = raddr[i];
    end
    b_wa = '0;
    r_ra = '0;
    for (int j = 0; j < N_RX; j++) begin
      if (strm_rx_ch == RW'(j)) b_wa = waddr[N_TX+j];
      if (dma_rx_ch == RW'(j))  r_ra = raddr[N_TX+j];
    end
  end

  sbf_store #(.AW(AW), .DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we_a (|wr_ok[N_TX-1:0]),
    .wa   (a_wa),
    .da   (dma_tx_data),
    .we_b (|wr_ok[NCH-1:N_TX]),
    .wb   (b_wa),
    .db   (strm_rx_data),
    .re_t (|rd_ok[N_TX-1:0]),
    .rt   (t_ra),
    .re_r (|rd_ok[NCH-1:N_TX]),
    .rr   (r_ra),
    .q_t  (strm_tx_data),
    .v_t  (strm_tx_dval),
    .q_r  (dma_rx_data),
    .v_r  (dma_rx_dval)
  );

  // per-word events toward the DMA
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_tx <= '0;
      evt_rx <= '0;
    end else begin
      evt_tx <= rd_ok[N_TX-1:0];
      evt_rx <= wr_ok[NCH-1:N_TX];
    end
  end

  // R5
  one_tx_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_tx));

  // R5
  tx_dval_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strm_tx_dval == (evt_tx != '0));

  for (genvar i = 0; i < N_TX; i++) begin : g_tx_chk
    // R5
    tx_evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_tx[i] |-> $past(strm_tx_pop && (strm_tx_ch == TW'(i)) && strm_tx_avail[i]));
  end

  for (genvar j = 0; j < N_RX; j++) begin : g_rx_chk
    // R6
    rx_evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rx[j] |-> $past(strm_rx_push && (strm_rx_ch == RW'(j))));
    // R7
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rx_re && (dma_rx_ch == RW'(j)) && !rx_avail[j] && !cfg_we) |=> !dma_rx_dval);
  end
endmodule

// File: tb/sim_sbf_stream_if.sv
module sim_sbf_stream_if;
  localparam int N_TX = 2, N_RX = 2, AW = 6, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0;            logic [1:0] cfg_ch = 0;
  logic [AW-1:0] cfg_base = 0; logic [AW:0] cfg_depth = 0, cfg_thresh = 0;
  logic dma_tx_we = 0;         logic [0:0] dma_tx_ch = 0; logic [DW-1:0] dma_tx_data = 0;
  logic dma_rx_re = 0;         logic [0:0] dma_rx_ch = 0;
  logic strm_tx_pop = 0;       logic [0:0] strm_tx_ch = 0;
  logic strm_rx_push = 0;      logic [0:0] strm_rx_ch = 0; logic [DW-1:0] strm_rx_data = 0;
  logic [DW-1:0] dma_rx_data, strm_tx_data;
  logic dma_rx_dval, strm_tx_dval;
  logic [N_TX-1:0] strm_tx_avail, evt_tx, err_tx;
  logic [N_RX-1:0] evt_rx, err_rx;

  int total = 0, fails = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  sbf_stream_if #(.N_TX(N_TX), .N_RX(N_RX), .AW(AW), .DATA_W(DW)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(int ch, int base, int dep, int thr);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_base = AW'(base);
    cfg_depth = (AW+1)'(dep); cfg_thresh = (AW+1)'(thr);
    @(posedge clk); #1ns cfg_we = 0;
  endtask

  task automatic tx_wr(int ch, int d);
    @(negedge clk);
    dma_tx_we = 1; dma_tx_ch = 1'(ch); dma_tx_data = DW'(d);
    @(posedge clk); #1ns dma_tx_we = 0;
  endtask

  // pop expected to succeed: data, valid and event one cycle after the edge
  task automatic tx_pop(int ch, int d, string req);
    @(negedge clk);
    strm_tx_pop = 1; strm_tx_ch = 1'(ch);
    @(posedge clk); #1ns strm_tx_pop = 0;
    chk(req, {strm_tx_dval, strm_tx_data}, {1'b1, DW'(d)});
    chk(req, evt_tx, 32'(1 << ch));
  endtask

  task automatic tx_pop_none(int ch, string req);
    @(negedge clk);
    strm_tx_pop = 1; strm_tx_ch = 1'(ch);
    @(posedge clk); #1ns strm_tx_pop = 0;
    chk(req, {strm_tx_dval, evt_tx}, 0);
  endtask

  task automatic rx_push(int ch, int d, bit expect_evt, string req);
    @(negedge clk);
    strm_rx_push = 1; strm_rx_ch = 1'(ch); strm_rx_data = DW'(d);
    @(posedge clk); #1ns strm_rx_push = 0;
    chk(req, evt_rx, expect_evt ? 32'(1 << ch) : 0);
  endtask

  task automatic rx_read(int ch, bit ok, int d, string req);
    @(negedge clk);
    dma_rx_re = 1; dma_rx_ch = 1'(ch);
    @(posedge clk); #1ns dma_rx_re = 0;
    chk(req, dma_rx_dval, ok);
    if (ok) chk(req, dma_rx_data, d);
  endtask

  task automatic t_reset;
    chk("R1 avail", strm_tx_avail, 0);
    chk("R1 events", {evt_tx, evt_rx}, 0);
    chk("R1 errors", {err_tx, err_rx}, 0);
    chk("R1 valids", {strm_tx_dval, dma_rx_dval}, 0);
    tx_wr(0, 16'h0bad);   // depth 0 after reset: write is an overflow
    chk("R1 depth0", err_tx, 2'b01);
  endtask

  task automatic t_setup;  // R2: cfg index 0,1 tx; 2,3 rx
    cfg(0, 0, 24, 16);
    chk("R10 err cleared", err_tx, 0);
    cfg(1, 24, 8, 4);
    cfg(2, 32, 4, 0);
    cfg(3, 36, 8, 0);
  endtask

  task automatic t_threshold;
    for (int k = 0; k < 8; k++) tx_wr(0, 16'h1000 + k);
    chk("R3 after one burst", strm_tx_avail, 0);
    for (int k = 8; k < 15; k++) tx_wr(0, 16'h1000 + k);
    chk("R3 level 15", strm_tx_avail, 0);
    tx_wr(0, 16'h100f);
    chk("R3 level 16", strm_tx_avail, 2'b01);
  endtask

  task automatic t_drain;
    tx_pop(0, 16'h1000, "R5 first pop");
    chk("R4 below level still open", strm_tx_avail, 2'b01);
    for (int k = 1; k < 16; k++) tx_pop(0, 16'h1000 + k, "R5 drain order");
    chk("R4 closed on empty", strm_tx_avail, 0);
    tx_pop_none(0, "R5 pop while unavailable");
    for (int k = 0; k < 4; k++) tx_wr(0, 16'h1010 + k);
    chk("R4 re-armed", strm_tx_avail, 0);
  endtask

  task automatic t_wrap;
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 6; k++) tx_wr(1, 16'h2000 + r * 6 + k);
      chk("R8 tx1 open", strm_tx_avail, 2'b10);
      for (int k = 0; k < 6; k++) tx_pop(1, 16'h2000 + r * 6 + k, "R8 wrap order");
    end
    for (int k = 4; k < 16; k++) tx_wr(0, 16'h1010 + k);
    chk("R8 tx0 open", strm_tx_avail, 2'b01);
    for (int k = 0; k < 16; k++) tx_pop(0, 16'h1010 + k, "R8 isolation");
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 8; k++) tx_wr(1, 16'h2100 + k);
    chk("R9 full no error", err_tx, 0);
    tx_wr(1, 16'h21ff);
    chk("R9 tx overflow", err_tx, 2'b10);
    for (int k = 0; k < 8; k++) tx_pop(1, 16'h2100 + k, "R9 dropped word");
    tx_pop_none(1, "R9 nothing after drop");
    chk("R9 sticky", err_tx, 2'b10);
    tx_wr(1, 16'h2200); tx_wr(1, 16'h2201);
    cfg(1, 24, 8, 4);
    chk("R10 cfg clears error", err_tx, 0);
    for (int k = 0; k < 3; k++) tx_wr(1, 16'h2210 + k);
    chk("R10 count cleared", strm_tx_avail, 0);
    tx_wr(1, 16'h2213);
    chk("R10 opens at level", strm_tx_avail, 2'b10);
    for (int k = 0; k < 4; k++) tx_pop(1, 16'h2210 + k, "R10 old words gone");
  endtask

  task automatic t_rx;
    for (int k = 0; k < 3; k++) rx_push(1, 16'h3000 + k, 1, "R6 push event");
    for (int k = 0; k < 3; k++) rx_read(1, 1, 16'h3000 + k, "R7 read order");
    rx_read(1, 0, 0, "R7 empty read");
    for (int k = 0; k < 4; k++) rx_push(0, 16'h3100 + k, 1, "R6 rx0 event");
    chk("R9 rx full no error", err_rx, 0);
    rx_push(0, 16'h31ff, 0, "R9 rx full no event");
    chk("R9 rx overflow", err_rx, 2'b01);
    for (int k = 0; k < 4; k++) rx_read(0, 1, 16'h3100 + k, "R9 rx kept words");
    rx_read(0, 0, 0, "R9 rx dropped word");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1ns t_reset_pre();
  end

  task automatic t_reset_pre;
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1ns;
    t_reset();
    t_setup();
    t_threshold();
    t_drain();
    t_wrap();
    t_overflow();
    t_rx();
    finish_run();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule